// File: doc/BRIEF.md
# Parallel Handshake I/O Port

This block is an 18-pin parallel port. Any pin can serve as plain general-purpose I/O. The pins can also carry strobed data toward an external peer, using a two-wire handshake. The pins form two groups: a low group of eight pins (7..0) and an upper group of ten pins (17..8). Each group has its own mode: plain GPIO, level-sensitive interlocked, edge-sensitive pulsed, or transparent (data with no handshake). A wide bit lets the low group's handshake engine own pins 15..0, which gives a 16-bit handshaked port. Each group has one control output and one control input. A transmitter uses them as strobe-out and acknowledge-in. A receiver uses them as strobe-in and acknowledge-out.

Software reaches the block through a simple register bus. Reads are combinational. Writes take effect on the clock edge. The registers are configuration, direction, data, open-drain, timing, event and mask. The setup delay and the strobe or acknowledge pulse width are programmed in clock cycles. Completed handshakes set event bits, and the mask register selects which event bits drive the interrupt line. Pins are modelled as separate input, output and output-enable vectors.

Top module: `hsport_top`

## Requirements
- R1: After synchronous reset, every output enable and both control outputs are low, the interrupt is low, and every register reads 0. The register addresses are: 0 config, 1 direction, 2 data, 3 open-drain, 4 timing, 5 event, 6 mask.
- R2: For pins of a group in GPIO mode (mode code 0), a pin's output value follows the last write to the data register (address 2). A read of address 2 returns the pin inputs as registered one cycle earlier.
- R3: A pin enables its output only when its bit in the direction register (address 1) is 1.
- R4: A pin whose open-drain bit (address 3) is 1 has an output value of 0. It enables its output only when its driven value would be 0.
- R5: The config register (address 0) holds these fields: low-group mode in bits 1:0, upper-group mode in bits 3:2, wide in bit 4, low transmit in bit 5, upper transmit in bit 6. The two groups run independently. With wide set, the low engine owns pins 15..0 and the upper group acts as GPIO.
- R6: Pulsed transmit (mode 2). A data write places the data on the owned pins. The strobe rises S+1 cycles after the write edge and stays high for P+1 cycles. S is timing bits 7:0 and P is timing bits 15:8.
- R7: Interlocked transmit (mode 1). The strobe stays high while the synchronized acknowledge is low. The strobe falls once the acknowledge is seen. The transmit event is raised only after the acknowledge is released.
- R8: Pulsed receive. On a rising edge of the synchronized input strobe, the block latches the group's pins, pulses the acknowledge high for P+1 cycles, and raises the receive event.
- R9: Interlocked receive. When the synchronized strobe is high, the block latches the pins, raises the receive event, and holds the acknowledge high until the strobe falls. Reads of the data register return the latched value.
- R10: Transparent mode (mode 3). In transmit, a data write drives the pins on the next cycle and raises the transmit event, with no strobe. In receive, data reads follow the pins.
- R11: The event register (address 5) has these bits: bit 0 low transmit done, bit 1 low receive, bit 2 upper transmit done, bit 3 upper receive. Writing 1 to a bit clears it. A new event wins over a clear in the same cycle.
- R12: The interrupt is high exactly when some event bit and its mask bit (address 6) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 18 | Register write data |
| reg_rdata | output | 18 | Register read data (combinational) |
| pin_in | input | 18 | Pin input levels |
| pin_out | output | 18 | Pin output values |
| pin_oe | output | 18 | Pin output enables |
| ctl_in | input | 2 | Per-group control input (bit 0 low, bit 1 upper) |
| ctl_out | output | 2 | Per-group control output (bit 0 low, bit 1 upper) |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench measures the pulsed strobe's delay and width against the programmed counts. An off-by-one counter would show as a setup or width one cycle off. It holds the acknowledge low for many cycles in interlocked transmit, so a design that dropped the strobe early or raised the event before the acknowledge was released is caught. On receive, it changes the pins after the handshake and reads the data again, which exposes a design that returns live pins instead of the latched value. It also covers the wide low group, open-drain pins driving high, and the write-one-to-clear event bits gating the interrupt.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
    localparam int PIN_N  = 18;
    localparam int LO_N   = 8;
    localparam int WIDE_N = 16;
    localparam int HI_N   = PIN_N - LO_N;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 3;
    localparam int EVT_W  = 4;

    localparam int EV_LO_TX = 0;
    localparam int EV_LO_RX = 1;
    localparam int EV_HI_TX = 2;
    localparam int EV_HI_RX = 3;

    typedef enum logic [1:0] {
        MODE_GPIO  = 2'd0,
        MODE_LEVEL = 2'd1,
        MODE_EDGE  = 2'd2,
        MODE_FLOW  = 2'd3
    } mode_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG  = 3'd0,
        A_DIR  = 3'd1,
        A_DATA = 3'd2,
        A_ODR  = 3'd3,
        A_TIM  = 3'd4,
        A_EVT  = 3'd5,
        A_MASK = 3'd6
    } addr_e;

    typedef struct packed {
        logic  hi_tx;
        logic  lo_tx;
        logic  wide;
        mode_e hi_mode;
        mode_e lo_mode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic logic [PIN_N-1:0] lo_span(input logic wide);
        logic [PIN_N-1:0] m;
        m = '0;
        for (int i = 0; i < PIN_N; i++)
            if (i < (wide ? WIDE_N : LO_N)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [PIN_N-1:0] hi_span();
        logic [PIN_N-1:0] m;
        m = '0;
        for (int i = LO_N; i < PIN_N; i++) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/hsport_sync.sv
module hsport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsport_engine.sv
module hsport_engine
    import hsport_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_e         mode,
    input  logic          tx,
    input  logic [CW-1:0] setup_len,
    input  logic [CW-1:0] pulse_len,
    input  logic          start,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_data,
    input  logic          ctl_in,
    output logic          ctl_out,
    output logic [W-1:0]  dout,
    output logic [W-1:0]  rx_data,
    output logic          tx_done,
    output logic          rx_done
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_STRB, ST_RELEASE, ST_RX_ACK, ST_RX_HOLD
    } st_e;

    st_e           state;
    logic [CW-1:0] cnt;
    logic          peer;
    logic          peer_d;
    logic          peer_rise;

    hsport_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_in),
        .q   (peer)
    );

    assign peer_rise = peer & ~peer_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            ctl_out <= 1'b0;
            dout    <= '0;
            rx_data <= '0;
            peer_d  <= 1'b0;
        end else begin
            peer_d <= peer;
            if (mode == MODE_GPIO) begin
                state   <= ST_IDLE;
                ctl_out <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (tx) begin
                            if (start) begin
                                dout <= wdata;
                                if (mode != MODE_FLOW) begin
                                    cnt   <= setup_len;
                                    state <= ST_SETUP;
                                end
                            end
                        end else if (mode == MODE_FLOW) begin
                            rx_data <= pin_data;
                        end else if (mode == MODE_EDGE && peer_rise) begin
                            rx_data <= pin_data;
                            ctl_out <= 1'b1;
                            cnt     <= pulse_len;
                            state   <= ST_RX_ACK;
                        end else if (mode == MODE_LEVEL && peer) begin
                            rx_data <= pin_data;
                            ctl_out <= 1'b1;
                            state   <= ST_RX_HOLD;
                        end
                    end
                    ST_SETUP: begin
                        if (cnt == '0) begin
                            ctl_out <= 1'b1;
                            cnt     <= pulse_len;
                            state   <= ST_STRB;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_STRB: begin
                        if (mode == MODE_LEVEL) begin
                            if (peer) begin
                                ctl_out <= 1'b0;
                                state   <= ST_RELEASE;
                            end
                        end else if (cnt == '0) begin
                            ctl_out <= 1'b0;
                            state   <= ST_IDLE;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_RELEASE: begin
                        if (!peer) state <= ST_IDLE;
                    end
                    ST_RX_ACK: begin
                        if (cnt == '0) begin
                            ctl_out <= 1'b0;
                            state   <= ST_IDLE;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_RX_HOLD: begin
                        if (!peer) begin
                            ctl_out <= 1'b0;
                            state   <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        tx_done = 1'b0;
        rx_done = 1'b0;
        if (mode != MODE_GPIO) begin
            case (state)
                ST_IDLE: begin
                    tx_done = tx & start & (mode == MODE_FLOW);
                    rx_done = ~tx & (((mode == MODE_EDGE) & peer_rise) |
                                     ((mode == MODE_LEVEL) & peer));
                end
                ST_STRB:    tx_done = (mode == MODE_EDGE) & (cnt == '0);
                ST_RELEASE: tx_done = ~peer;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hsport_pinmux.sv
module hsport_pinmux #(
    parameter int N = 18
) (
    input  logic [N-1:0] own0,
    input  logic [N-1:0] own1,
    input  logic [N-1:0] dout0,
    input  logic [N-1:0] dout1,
    input  logic [N-1:0] gpio,
    input  logic [N-1:0] dir,
    input  logic [N-1:0] od,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic raw;
        assign raw        = own0[g] ? dout0[g] : (own1[g] ? dout1[g] : gpio[g]);
        assign pin_out[g] = raw & ~od[g];
        assign pin_oe[g]  = dir[g] & ~(od[g] & raw);
    end
endmodule

// File: rtl/hsport_top.sv
module hsport_top
    import hsport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [PIN_N-1:0]  reg_wdata,
    output logic [PIN_N-1:0]  reg_rdata,
    input  logic [PIN_N-1:0]  pin_in,
    output logic [PIN_N-1:0]  pin_out,
    output logic [PIN_N-1:0]  pin_oe,
    input  logic [1:0]        ctl_in,
    output logic [1:0]        ctl_out,
    output logic              irq
);
    cfg_t             cfg_q;
    logic [PIN_N-1:0] dir_q, od_q, gpio_q, pin_q;
    logic [CNT_W-1:0] setup_q, pulse_q;
    logic [EVT_W-1:0] evt_q, mask_q, evt_set, evt_clr;

    mode_e            hi_mode_eff;
    logic [PIN_N-1:0] own0, own1, rx0, rx1;
    logic [PIN_N-1:0] dout0_w, dout1_w, rxd0_w, rxd1_w, data_rd;
    logic [WIDE_N-1:0] dout0, rxd0;
    logic [HI_N-1:0]   dout1, rxd1;
    logic             start;
    logic             txd0, rxe0, txd1, rxe1;

    assign start       = reg_we && (reg_addr == A_DATA);
    assign hi_mode_eff = cfg_q.wide ? MODE_GPIO : cfg_q.hi_mode;

    hsport_engine #(.W(WIDE_N), .CW(CNT_W)) u_eng_lo (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_q.lo_mode),
        .tx        (cfg_q.lo_tx),
        .setup_len (setup_q),
        .pulse_len (pulse_q),
        .start     (start),
        .wdata     (reg_wdata[WIDE_N-1:0]),
        .pin_data  (pin_in[WIDE_N-1:0]),
        .ctl_in    (ctl_in[0]),
        .ctl_out   (ctl_out[0]),
        .dout      (dout0),
        .rx_data   (rxd0),
        .tx_done   (txd0),
        .rx_done   (rxe0)
    );

    hsport_engine #(.W(HI_N), .CW(CNT_W)) u_eng_hi (
        .clk       (clk),
        .rst       (rst),
        .mode      (hi_mode_eff),
        .tx        (cfg_q.hi_tx),
        .setup_len (setup_q),
        .pulse_len (pulse_q),
        .start     (start),
        .wdata     (reg_wdata[PIN_N-1:LO_N]),
        .pin_data  (pin_in[PIN_N-1:LO_N]),
        .ctl_in    (ctl_in[1]),
        .ctl_out   (ctl_out[1]),
        .dout      (dout1),
        .rx_data   (rxd1),
        .tx_done   (txd1),
        .rx_done   (rxe1)
    );

    assign own0    = (cfg_q.lo_mode != MODE_GPIO) ? lo_span(cfg_q.wide) : '0;
    assign own1    = (hi_mode_eff != MODE_GPIO) ? hi_span() : '0;
    assign rx0     = own0 & {PIN_N{~cfg_q.lo_tx}};
    assign rx1     = own1 & {PIN_N{~cfg_q.hi_tx}};
    assign dout0_w = {{(PIN_N-WIDE_N){1'b0}}, dout0};
    assign rxd0_w  = {{(PIN_N-WIDE_N){1'b0}}, rxd0};
    assign dout1_w = {dout1, {LO_N{1'b0}}};
    assign rxd1_w  = {rxd1, {LO_N{1'b0}}};
    assign data_rd = (rx0 & rxd0_w) | (rx1 & rxd1_w) | (~(rx0 | rx1) & pin_q);

    hsport_pinmux #(.N(PIN_N)) u_pinmux (
        .own0    (own0),
        .own1    (own1),
        .dout0   (dout0_w),
        .dout1   (dout1_w),
        .gpio    (gpio_q),
        .dir     (dir_q),
        .od      (od_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    always_comb begin
        evt_set           = '0;
        evt_set[EV_LO_TX] = txd0;
        evt_set[EV_LO_RX] = rxe0;
        evt_set[EV_HI_TX] = txd1;
        evt_set[EV_HI_RX] = rxe1;
        evt_clr = (reg_we && reg_addr == A_EVT) ? reg_wdata[EVT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            dir_q   <= '0;
            od_q    <= '0;
            gpio_q  <= '0;
            pin_q   <= '0;
            setup_q <= '0;
            pulse_q <= '0;
            evt_q   <= '0;
            mask_q  <= '0;
        end else begin
            pin_q <= pin_in;
            evt_q <= (evt_q & ~evt_clr) | evt_set;
            if (reg_we) begin
                case (reg_addr)
                    A_CFG:  cfg_q  <= cfg_t'(reg_wdata[CFG_W-1:0]);
                    A_DIR:  dir_q  <= reg_wdata;
                    A_DATA: gpio_q <= reg_wdata;
                    A_ODR:  od_q   <= reg_wdata;
                    A_TIM: begin
                        setup_q <= reg_wdata[CNT_W-1:0];
                        pulse_q <= reg_wdata[2*CNT_W-1:CNT_W];
                    end
                    A_MASK: mask_q <= reg_wdata[EVT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_CFG:   reg_rdata = {{(PIN_N-CFG_W){1'b0}}, cfg_q};
            A_DIR:   reg_rdata = dir_q;
            A_DATA:  reg_rdata = data_rd;
            A_ODR:   reg_rdata = od_q;
            A_TIM:   reg_rdata = {{(PIN_N-2*CNT_W){1'b0}}, pulse_q, setup_q};
            A_EVT:   reg_rdata = {{(PIN_N-EVT_W){1'b0}}, evt_q};
            A_MASK:  reg_rdata = {{(PIN_N-EVT_W){1'b0}}, mask_q};
            default: reg_rdata = '0;
        endcase
    end

    assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/hsport_checker.sv
module hsport_checker
    import hsport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [PIN_N-1:0]  reg_wdata,
    input logic [PIN_N-1:0]  pin_out,
    input logic [PIN_N-1:0]  pin_oe,
    input logic [PIN_N-1:0]  dir_q,
    input logic [PIN_N-1:0]  od_q,
    input logic [1:0]        ctl_in,
    input logic [1:0]        ctl_out,
    input logic [CFG_W-1:0]  cfg_bits,
    input logic [EVT_W-1:0]  evt_q,
    input logic [EVT_W-1:0]  evt_set
);
    AST_DIR_GATE: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & ~dir_q) == '0);  // R3

    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (od_q & (pin_out | ({PIN_N{1'b0}} | pin_oe & pin_out))) == '0);  // R4

    AST_LEVEL_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_bits[1:0] == 2'd1 && cfg_bits[5] && $stable(cfg_bits) &&
         $past(ctl_out[0]) && !$past(ctl_in[0]) && !$past(ctl_in[0], 2))
        |-> ctl_out[0]);  // R7

    AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_we) && $past(reg_addr) == A_EVT && $past(reg_wdata[0]) &&
         !$past(evt_set[0])) |-> !evt_q[0]);  // R11
endmodule

bind hsport_top hsport_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .ctl_in    (ctl_in),
    .ctl_out   (ctl_out),
    .cfg_bits  (cfg_q),
    .evt_q     (evt_q),
    .evt_set   (evt_set)
);

// File: tb/hsport_top_bench.sv
module hsport_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  reg_addr;
    logic        reg_we;
    logic [17:0] reg_wdata, reg_rdata, pin_in, pin_out, pin_oe;
    logic [1:0]  ctl_in, ctl_out;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hsport_top u_hsport_top (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .ctl_in(ctl_in),
        .ctl_out(ctl_out), .irq(irq)
    );

    // {dir, od, data, expected oe, expected out}
    localparam int NV = 5;
    localparam logic [89:0] VEC [NV] = '{
        {18'h3FFFF, 18'h00000, 18'h15A5A, 18'h3FFFF, 18'h15A5A},
        {18'h000FF, 18'h00000, 18'h3FFFF, 18'h000FF, 18'h3FFFF},
        {18'h3FFFF, 18'h3FFFF, 18'h0F0F0, 18'h30F0F, 18'h00000},
        {18'h0FF00, 18'h00F00, 18'h3FF00, 18'h0F000, 18'h3F000},
        {18'h00000, 18'h00000, 18'h2AAAA, 18'h00000, 18'h2AAAA}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [17:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [17:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_ctl(input int idx, input logic lvl, input int lim, output int n);
        n = 0;
        while (ctl_out[idx] !== lvl && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [17:0] d;
        int n;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        pin_in = '0; ctl_in = '0;
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        chk("R1 oe", pin_oe, 0);
        chk("R1 ctl", ctl_out, 0);
        chk("R1 irq", irq, 0);
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], d);
            chk("R1 reg", d, 0);
        end

        // R2 R3 R4 table
        for (int i = 0; i < NV; i++) begin
            wr(3'd1, VEC[i][89:72]);
            wr(3'd3, VEC[i][71:54]);
            wr(3'd2, VEC[i][53:36]);
            chk("R3/R4 oe", pin_oe, VEC[i][35:18]);
            chk("R2/R4 out", pin_out, VEC[i][17:0]);
        end
        wr(3'd3, 18'h0);

        // R2 read of pins
        pin_in = 18'h12345;
        idle(2);
        rd(3'd2, d);
        chk("R2 read", d, 18'h12345);
        pin_in = '0;

        // R6 pulsed transmit, low group; upper group stays GPIO (R5)
        wr(3'd1, 18'h3FFFF);
        wr(3'd4, {2'b0, 8'd2, 8'd3});
        wr(3'd0, 18'h22);
        wr(3'd2, 18'h2B4A5);
        wait_ctl(0, 1'b1, 20, n);
        chk("R6 setup", n, 4);
        chk("R6 data", pin_out[7:0], 8'hA5);
        chk("R5 upper gpio", pin_out[17:8], 10'h2B4);
        n = 1;
        @(negedge clk);
        while (ctl_out[0] && n < 20) begin n++; @(negedge clk); end
        chk("R6 width", n, 3);
        rd(3'd5, d);
        chk("R11 tx evt", d, 18'h1);
        chk("R12 masked", irq, 0);
        wr(3'd6, 18'h1);
        chk("R12 irq", irq, 1);
        wr(3'd5, 18'h1);
        chk("R11 w1c irq", irq, 0);
        rd(3'd5, d);
        chk("R11 w1c", d, 0);

        // R7 interlocked transmit
        wr(3'd4, 18'h0);
        wr(3'd0, 18'h21);
        wr(3'd2, 18'h0003C);
        wait_ctl(0, 1'b1, 10, n);
        chk("R7 strobe up", ctl_out[0], 1);
        idle(6);
        chk("R7 hold", ctl_out[0], 1);
        ctl_in[0] = 1'b1;
        wait_ctl(0, 1'b0, 10, n);
        chk("R7 strobe down", ctl_out[0], 0);
        rd(3'd5, d);
        chk("R7 evt waits", d[0], 0);
        ctl_in[0] = 1'b0;
        idle(5);
        rd(3'd5, d);
        chk("R7 evt", d[0], 1);
        wr(3'd5, 18'hF);

        // R10 transparent transmit
        wr(3'd0, 18'h23);
        wr(3'd2, 18'h0005A);
        chk("R10 drive", pin_out[7:0], 8'h5A);
        chk("R10 no strobe", ctl_out[0], 0);
        rd(3'd5, d);
        chk("R10 evt", d[0], 1);
        wr(3'd5, 18'hF);

        // R10 transparent receive
        wr(3'd1, 18'h0);
        wr(3'd0, 18'h03);
        pin_in = 18'h00077;
        idle(3);
        rd(3'd2, d);
        chk("R10 rx", d[7:0], 8'h77);

        // R8 pulsed receive, upper group
        wr(3'd0, 18'h08);
        wr(3'd4, {2'b0, 8'd1, 8'd0});
        pin_in = {10'h2C3, 8'h00};
        @(negedge clk);
        ctl_in[1] = 1'b1;
        wait_ctl(1, 1'b1, 10, n);
        chk("R8 ack", ctl_out[1], 1);
        n = 1;
        @(negedge clk);
        while (ctl_out[1] && n < 20) begin n++; @(negedge clk); end
        chk("R8 ack width", n, 2);
        ctl_in[1] = 1'b0;
        pin_in = '0;
        idle(3);
        rd(3'd2, d);
        chk("R8 latched", d[17:8], 10'h2C3);
        rd(3'd5, d);
        chk("R8 evt", d, 18'h8);
        wr(3'd5, 18'hF);

        // R9 interlocked receive, wide low group (R5)
        wr(3'd0, 18'h11);
        pin_in = 18'h0BEEF;
        @(negedge clk);
        ctl_in[0] = 1'b1;
        wait_ctl(0, 1'b1, 10, n);
        chk("R9 ack", ctl_out[0], 1);
        pin_in = 18'h00000;
        idle(4);
        chk("R9 ack held", ctl_out[0], 1);
        rd(3'd2, d);
        chk("R9/R5 wide data", d[15:0], 16'hBEEF);
        rd(3'd5, d);
        chk("R9 evt", d, 18'h2);
        ctl_in[0] = 1'b0;
        wait_ctl(0, 1'b0, 10, n);
        chk("R9 ack release", ctl_out[0], 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule